// File: doc/BRIEF.md
# Key Readout Guard with Single-Use Words

This block sits between a register bus and two key banks that other logic supplies: a symmetric key and an asymmetric key, each eight 32-bit words wide. A bus read of a key word passes that word to the read data only when policy allows it. Otherwise the read returns zero, and the bus never sees an error.

Two policies apply. First, each word of the asymmetric key is destroyed by reading it: after the first read of a word, every later read of that word returns zero until the next reset. Second, a control word holds one inhibit flag per bank. Software can set a flag but cannot clear it. A set flag zeroes all reads of its bank until reset.

Read data is registered, so the value for a read issued in one cycle appears on the next cycle. The block creates no keys; the key inputs are assumed to be stable.

Top module: `keyguard_top`

## Requirements
- R1: A synchronous active-high reset clears both inhibit flags and all single-use tracking, and drives the read data to zero. After reset, every asymmetric word can be read once again.
- R2: A read at byte address 4*i, for i from 0 to 7, returns bits [32i+31:32i] of the symmetric key on the cycle after the read. This holds while the symmetric inhibit flag is clear, and the word can be read any number of times.
- R3: A read at byte address 0x20+4*i returns bits [32i+31:32i] of the asymmetric key on the cycle after the read. This holds for the first read of that word since reset, while the asymmetric inhibit flag is clear.
- R4: Each later read of an asymmetric word that has already been read returns zero. Words not yet read are unaffected.
- R5: A read at byte address 0x4C returns the control word. Bit 0 is the symmetric inhibit flag, bit 16 is the asymmetric inhibit flag, and all other bits read zero.
- R6: A write to 0x4C with bit 0 (or bit 16) at 1 sets the matching flag. A write with the bit at 0 leaves the flag unchanged, so a set flag stays set until reset.
- R7: While the symmetric inhibit flag is set, every symmetric word reads as zero.
- R8: While the asymmetric inhibit flag is set, every asymmetric word reads as zero, including words never read before.
- R9: Read data is zero in any cycle that follows a cycle without a read. Reads of unaligned or unmapped addresses return zero. Writes to key addresses do not change what key reads return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_en | input | 1 | Read strobe for the current address |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | 7 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| sym_key | input | 256 | Symmetric key, word i in bits [32i+31:32i] |
| asym_key | input | 256 | Asymmetric key, word i in bits [32i+31:32i] |

## Verification
The bench repeats reads of the same asymmetric word, both directly after the first read and after reads of other words. A design that keeps one shared flag, or tracks by the wrong index, would either leak a second copy or zero words that were never read.

It writes zeros and other bits to the control word after a flag has been set. A flag that can be cleared, or that responds to the wrong bit position, would reopen a bank.

It pulses reset in the middle of a run to confirm that tracking restarts. It also mixes unaligned, unmapped and key-address writes into random traffic. A loose address decode would then alias into a bank, and a writable key word would corrupt later reads.

// File: rtl/keyguard_pkg.sv
package keyguard_pkg;

    localparam int KG_WORD_W        = 32;
    localparam int KG_NUM_WORDS     = 8;
    localparam int KG_ADDR_W        = 7;
    localparam int KG_CTRL_OFS      = 'h4C;
    localparam int KG_SYM_BLK_BIT   = 0;
    localparam int KG_ASYM_BLK_BIT  = 16;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_SYM  = 2'd1,
        RGN_ASYM = 2'd2,
        RGN_CTRL = 2'd3
    } region_e;

    typedef struct packed {
        logic sym;
        logic asym;
    } inhibit_t;

    function automatic logic [KG_WORD_W-1:0] pick_word(
        input logic [KG_NUM_WORDS*KG_WORD_W-1:0] bank,
        input int unsigned                       idx
    );
        return bank[idx*KG_WORD_W +: KG_WORD_W];
    endfunction

endpackage

// File: rtl/keyguard_decode.sv
module keyguard_decode
    import keyguard_pkg::*;
#(
    parameter int ADDR_W    = KG_ADDR_W,
    parameter int NUM_WORDS = KG_NUM_WORDS,
    parameter int WORD_W    = KG_WORD_W,
    parameter int CTRL_OFS  = KG_CTRL_OFS
) (
    input  logic [ADDR_W-1:0]            addr_i,
    output region_e                      rgn_o,
    output logic [$clog2(NUM_WORDS)-1:0] idx_o
);
    localparam int IDX_W     = $clog2(NUM_WORDS);
    localparam int BANK_SZ   = NUM_WORDS * (WORD_W / 8);
    localparam logic [ADDR_W-1:0] ASYM_LO = ADDR_W'(BANK_SZ);
    localparam logic [ADDR_W-1:0] ASYM_HI = ADDR_W'(2 * BANK_SZ);
    localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(CTRL_OFS);

    always_comb begin
        rgn_o = RGN_NONE;
        if (addr_i[1:0] == 2'b00) begin
            if (addr_i < ASYM_LO)       rgn_o = RGN_SYM;
            else if (addr_i < ASYM_HI)  rgn_o = RGN_ASYM;
            else if (addr_i == CTRL_A)  rgn_o = RGN_CTRL;
        end
    end

    assign idx_o = addr_i[IDX_W+1:2];

endmodule

// File: rtl/keyguard_lockbits.sv
module keyguard_lockbits
    import keyguard_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_i,
    input  inhibit_t set_i,
    output inhibit_t inh_o
);
    inhibit_t inh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            inh_q <= '0;
        end else if (wr_i) begin
            inh_q.sym  <= inh_q.sym  | set_i.sym;
            inh_q.asym <= inh_q.asym | set_i.asym;
        end
    end

    assign inh_o = inh_q;

    p_sym_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        inh_q.sym |=> inh_q.sym);
    p_asym_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        inh_q.asym |=> inh_q.asym);
    p_hold_without_write_r6: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> $stable(inh_q));

endmodule

// File: rtl/keyguard_once.sv
module keyguard_once #(
    parameter int NUM_WORDS = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         take_i,
    input  logic [$clog2(NUM_WORDS)-1:0] idx_i,
    output logic [NUM_WORDS-1:0]         used_o
);
    logic [NUM_WORDS-1:0] used_q;

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                used_q[g] <= 1'b0;
            else if (take_i && (int'(idx_i) == g))
                used_q[g] <= 1'b1;
        end

        p_used_hold_r4: assert property (@(posedge clk) disable iff (rst)
            used_q[g] |=> used_q[g]);
    end

    assign used_o = used_q;

    p_one_new_per_cycle_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $countones(used_q & ~$past(used_q)) <= 1);

endmodule

// File: rtl/keyguard_top.sv
module keyguard_top
    import keyguard_pkg::*;
#(
    parameter int WORD_W        = KG_WORD_W,
    parameter int NUM_WORDS     = KG_NUM_WORDS,
    parameter int ADDR_W        = KG_ADDR_W,
    parameter int CTRL_OFS      = KG_CTRL_OFS,
    parameter int SYM_BLK_BIT   = KG_SYM_BLK_BIT,
    parameter int ASYM_BLK_BIT  = KG_ASYM_BLK_BIT
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        rd_en,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [WORD_W-1:0]           wdata,
    output logic [WORD_W-1:0]           rdata,
    input  logic [NUM_WORDS*WORD_W-1:0] sym_key,
    input  logic [NUM_WORDS*WORD_W-1:0] asym_key
);
    localparam int IDX_W = $clog2(NUM_WORDS);

    region_e              rgn;
    logic [IDX_W-1:0]     idx;
    inhibit_t             inh;
    inhibit_t             set_req;
    logic [NUM_WORDS-1:0] used;
    logic [WORD_W-1:0]    rd_nxt;
    logic [WORD_W-1:0]    rdata_q;
    logic                 unused_wdata;

    assign unused_wdata = ^wdata;

    keyguard_decode #(
        .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .CTRL_OFS(CTRL_OFS)
    ) u_decode (
        .addr_i(addr), .rgn_o(rgn), .idx_o(idx)
    );

    assign set_req.sym  = wdata[SYM_BLK_BIT];
    assign set_req.asym = wdata[ASYM_BLK_BIT];

    keyguard_lockbits u_lock (
        .clk(clk), .rst(rst),
        .wr_i(wr_en && rgn == RGN_CTRL),
        .set_i(set_req),
        .inh_o(inh)
    );

    keyguard_once #(.NUM_WORDS(NUM_WORDS)) u_once (
        .clk(clk), .rst(rst),
        .take_i(rd_en && rgn == RGN_ASYM),
        .idx_i(idx),
        .used_o(used)
    );

    always_comb begin
        rd_nxt = '0;
        if (rd_en) begin
            unique case (rgn)
                RGN_SYM:  if (!inh.sym)
                              rd_nxt = sym_key[int'(idx)*WORD_W +: WORD_W];
                RGN_ASYM: if (!inh.asym && !used[idx])
                              rd_nxt = asym_key[int'(idx)*WORD_W +: WORD_W];
                RGN_CTRL: begin
                              rd_nxt[SYM_BLK_BIT]  = inh.sym;
                              rd_nxt[ASYM_BLK_BIT] = inh.asym;
                          end
                default:  rd_nxt = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rdata_q <= '0;
        else     rdata_q <= rd_nxt;
    end

    assign rdata = rdata_q;

    p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> rdata == '0);
    p_sym_blocked_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rgn == RGN_SYM && inh.sym) |=> rdata == '0);
    p_asym_blocked_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rgn == RGN_ASYM && inh.asym) |=> rdata == '0);
    p_second_read_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rgn == RGN_ASYM && used[idx]) |=> rdata == '0);
    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> rdata == '0);

endmodule

// File: tb/keyguard_top_tb_top.sv
module keyguard_top_tb_top;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         rd_en = 1'b0;
    logic         wr_en = 1'b0;
    logic [6:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic [255:0] sym_key;
    logic [255:0] asym_key;

    int  checks = 0;
    int  errors = 0;
    bit  m_sym_blk, m_asym_blk;
    bit  [7:0] m_used;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    keyguard_top dut_i (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .sym_key(sym_key), .asym_key(asym_key)
    );

    function automatic logic [31:0] key_word(logic [255:0] k, int i);
        return k[i*32 +: 32];
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; rd_en = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_sym_blk = 0; m_asym_blk = 0; m_used = '0;
    endtask

    task automatic rd(logic [6:0] a, string tag_in);
        logic [31:0] exp;
        string tag;
        int    i;
        exp = '0;
        i   = int'(a[4:2]);
        if (a[1:0] != 2'b00) begin
            tag = "R9";
        end else if (a < 7'h20) begin
            tag = m_sym_blk ? "R7" : "R2";
            exp = m_sym_blk ? 32'h0 : key_word(sym_key, i);
        end else if (a < 7'h40) begin
            tag = m_asym_blk ? "R8" : (m_used[i] ? "R4" : "R3");
            exp = (m_asym_blk || m_used[i]) ? 32'h0 : key_word(asym_key, i);
            m_used[i] = 1'b1;
        end else if (a == 7'h4C) begin
            tag = "R5";
            exp = {15'h0, m_asym_blk, 15'h0, m_sym_blk};
        end else begin
            tag = "R9";
        end
        if (tag_in != "") tag = tag_in;
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(tag, rdata, exp);
    endtask

    task automatic wr(logic [6:0] a, logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 7'h4C) begin
            m_sym_blk  = m_sym_blk  | d[0];
            m_asym_blk = m_asym_blk | d[16];
        end
    endtask

    task automatic idle_check();
        @(negedge clk);
        check("R9", rdata, 32'h0);
    endtask

    task automatic random_run(int n);
        for (int k = 0; k < n; k++) begin
            int unsigned op;
            logic [6:0]  a;
            logic [31:0] d;
            op = $urandom % 10;
            a  = 7'(($urandom % 21) * 4);
            if ($urandom % 20 == 0) a = a | 7'h1;
            d  = $urandom;
            if (op < 7) begin
                rd(a, "");
            end else if (op < 9) begin
                if ($urandom % 25 != 0) d = d & ~32'h0001_0001;
                wr(7'h4C, d);
            end else begin
                wr(a, d);
            end
            if (k % 37 == 0) idle_check();
        end
    endtask

    initial begin
        int unsigned seed_sink;
        seed_sink = $urandom(32'd20240611);
        for (int w = 0; w < 8; w++) begin
            sym_key[w*32 +: 32]  = $urandom;
            asym_key[w*32 +: 32] = $urandom;
        end
        do_reset();
        @(negedge clk);
        check("R1", rdata, 32'h0);
        rd(7'h4C, "R1");

        for (int i = 0; i < 8; i++) rd(7'(i*4), "R2");
        rd(7'h08, "R2");
        for (int i = 0; i < 8; i++) rd(7'(32 + i*4), "R3");
        rd(7'h2C, "R4");
        rd(7'h20, "R4");
        rd(7'h3C, "R4");
        rd(7'h21, "R9");
        rd(7'h44, "R9");
        rd(7'h7C, "R9");
        wr(7'h04, 32'hDEAD_BEEF);
        wr(7'h24, 32'h1234_5678);
        rd(7'h04, "R9");
        idle_check();
        wr(7'h4C, 32'hFFFE_FFFE);
        rd(7'h4C, "R6");

        do_reset();
        rd(7'h2C, "R1");
        rd(7'h4C, "R1");

        wr(7'h4C, 32'h0000_0001);
        rd(7'h4C, "R5");
        rd(7'h08, "R7");
        rd(7'h1C, "R7");
        rd(7'h30, "R3");
        wr(7'h4C, 32'h0000_0000);
        rd(7'h4C, "R6");
        rd(7'h00, "R6");
        wr(7'h4C, 32'h0001_0000);
        rd(7'h4C, "R5");
        rd(7'h34, "R8");
        rd(7'h38, "R8");
        wr(7'h4C, 32'h0000_0000);
        rd(7'h34, "R6");

        do_reset();
        rd(7'h34, "R1");
        rd(7'h00, "R1");
        random_run(400);
        do_reset();
        random_run(400);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule